// File: doc/BRIEF.md
# LED Channel Fault Qualifier and Reporter

This block watches the comparator outputs of a bank of LED current sinks and a few chip-level health indications. It filters out brief glitches, then records the faults that pass as sticky flags. Each channel has its own open comparator and its own short comparator. A channel fault counts only after its comparator has stayed high for a programmable number of PWM clock ticks. The two chip-level warnings, supply sagging and die temperature rising, count only after a fixed number of system clock cycles. A power-on flag is raised by reset.

Every recorded flag stays set until software clears it. One clear command handles the fault flags and a separate command handles the power-on flag. A set of masks selects which flags may drive the active-low fault pin. The masks can hide one channel, all opens, all shorts, or a single warning. Hard undervoltage and thermal shutdown always pull the pin, whatever the masks say. The pin is brought out as a drive-low enable for an external open-drain pad.

Top module: `led_fault_monitor`

## Requirements
- R1: The open flag of channel i (open_flags[i]) sets once open_cmp[i] has stayed high across N pulses of pwm_tick, where N = 8*(wait_sel+1). The codes 0, 1, 2 and 3 give 8, 16, 24 and 32. The flag is still clear after N-1 pulses. It becomes visible in the second clock cycle after the Nth pulse.
- R2: When a comparator input drops low for even one cycle before qualifying, that channel's tick count restarts from zero.
- R3: The short flag of channel i (short_flags[i]) qualifies from short_cmp[i] in the same way as R1.
- R4: sum_open is high exactly when some open_flags bit is set. sum_short is high exactly when some short_flags bit is set.
- R5: flag_preot sets once preot_in has been high for WARN_CYCLES consecutive clock cycles, and becomes visible one cycle after that. flag_preuv qualifies from preuv_in in the same way. A shorter high period leaves the flag clear.
- R6: Every fault flag stays set after its condition goes away, until clr_fault is pulsed.
- R7: A one-cycle clr_fault clears all open, short, pre-overtemperature and pre-undervoltage flags on the next edge and restarts every qualifying count. If a condition is still present, its flag sets again only after a full new qualification.
- R8: flag_por is 1 after reset. Only clr_por clears it, and clr_fault leaves it unchanged.
- R9: fault_pull (1 = drive the pin low) is 1 exactly when at least one of these holds: an open flag whose mask_open_ch bit is 0 while mask_open_all is 0; a short flag whose mask_short_ch bit is 0 while mask_short_all is 0; flag_preot with mask_preot 0; flag_preuv with mask_preuv 0; flag_por with mask_por 0; or R10.
- R10: uvlo_in or otsd_in high forces fault_pull to 1 in the same cycle, whatever the masks say.
- R11: Masks only affect fault_pull. A masked source still sets its flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, the timebase for warnings |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_tick | input | 1 | One-cycle PWM clock enable used for channel persistence |
| wait_sel | input | 2 | Channel persistence code (8, 16, 24, 32 ticks) |
| open_cmp | input | NCH | Per-channel open comparator outputs |
| short_cmp | input | NCH | Per-channel short comparator outputs |
| preuv_in | input | 1 | Supply sagging toward the undervoltage limit |
| preot_in | input | 1 | Die temperature above the warning level |
| uvlo_in | input | 1 | Hard undervoltage condition |
| otsd_in | input | 1 | Thermal shutdown condition |
| mask_open_ch | input | NCH | Per-channel open mask |
| mask_open_all | input | 1 | Mask for all open faults |
| mask_short_ch | input | NCH | Per-channel short mask |
| mask_short_all | input | 1 | Mask for all short faults |
| mask_preot | input | 1 | Pre-overtemperature mask |
| mask_preuv | input | 1 | Pre-undervoltage mask |
| mask_por | input | 1 | Power-on flag mask |
| clr_fault | input | 1 | Clear command for fault flags |
| clr_por | input | 1 | Clear command for the power-on flag |
| open_flags | output | NCH | Sticky per-channel open flags |
| short_flags | output | NCH | Sticky per-channel short flags |
| sum_open | output | 1 | Summary open flag |
| sum_short | output | 1 | Summary short flag |
| flag_preot | output | 1 | Sticky pre-overtemperature flag |
| flag_preuv | output | 1 | Sticky pre-undervoltage flag |
| flag_por | output | 1 | Power-on flag |
| fault_pull | output | 1 | Drive-low enable for the fault pin |

## Verification
The properties assume that clr_fault and clr_por are single-cycle pulses. They also assume that WARN_CYCLES is at least one, so that nothing can re-qualify in the cycle right after a clear. The stimulus keeps to this by raising each command for exactly one cycle, from a task, between negative clock edges. pwm_tick is likewise raised for one cycle at a time. Comparator inputs and masks change only on negative edges, so no property sees an input that moves at a sampling edge.

// File: rtl/led_fault_monitor.sv
module led_fault_monitor #(
  parameter int NCH         = 12,
  parameter int WARN_CYCLES = 528
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pwm_tick,
  input  logic [1:0]     wait_sel,
  input  logic [NCH-1:0] open_cmp,
  input  logic [NCH-1:0] short_cmp,
  input  logic           preuv_in,
  input  logic           preot_in,
  input  logic           uvlo_in,
  input  logic           otsd_in,
  input  logic [NCH-1:0] mask_open_ch,
  input  logic           mask_open_all,
  input  logic [NCH-1:0] mask_short_ch,
  input  logic           mask_short_all,
  input  logic           mask_preot,
  input  logic           mask_preuv,
  input  logic           mask_por,
  input  logic           clr_fault,
  input  logic           clr_por,
  output logic [NCH-1:0] open_flags,
  output logic [NCH-1:0] short_flags,
  output logic           sum_open,
  output logic           sum_short,
  output logic           flag_preot,
  output logic           flag_preuv,
  output logic           flag_por,
  output logic           fault_pull
);
  localparam int CW  = 6;
  localparam int WCW = $clog2(WARN_CYCLES + 1);

  logic [CW-1:0] limit;
  assign limit = ({4'b0, wait_sel} + 6'd1) << 3;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [CW-1:0] ocnt, scnt;
    logic          oflag, sflag;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ocnt <= '0;
        scnt <= '0;
      end else begin
        if (clr_fault || !open_cmp[g])              ocnt <= '0;
        else if (pwm_tick && ocnt < limit)          ocnt <= ocnt + 1'b1;
        if (clr_fault || !short_cmp[g])             scnt <= '0;
        else if (pwm_tick && scnt < limit)          scnt <= scnt + 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        oflag <= 1'b0;
        sflag <= 1'b0;
      end else if (clr_fault) begin
        oflag <= 1'b0;
        sflag <= 1'b0;
      end else begin
        if (open_cmp[g] && ocnt >= limit)  oflag <= 1'b1;
        if (short_cmp[g] && scnt >= limit) sflag <= 1'b1;
      end
    end

    assign open_flags[g]  = oflag;
    assign short_flags[g] = sflag;
  end

  logic [1:0] warn_in, warn_flag;
  assign warn_in = {preuv_in, preot_in};

  for (genvar w = 0; w < 2; w++) begin : g_warn
    logic [WCW-1:0] wcnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   wcnt <= '0;
      else if (clr_fault || !warn_in[w])            wcnt <= '0;
      else if (wcnt < WCW'(WARN_CYCLES))            wcnt <= wcnt + 1'b1;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                          warn_flag[w] <= 1'b0;
      else if (clr_fault)                                  warn_flag[w] <= 1'b0;
      else if (warn_in[w] && wcnt >= WCW'(WARN_CYCLES))    warn_flag[w] <= 1'b1;
    end
  end

  assign flag_preot = warn_flag[0];
  assign flag_preuv = warn_flag[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_por <= 1'b1;
    else if (clr_por) flag_por <= 1'b0;
  end

  assign sum_open  = |open_flags;
  assign sum_short = |short_flags;

  logic open_vis, short_vis, warn_vis;
  assign open_vis  = !mask_open_all  && |(open_flags  & ~mask_open_ch);
  assign short_vis = !mask_short_all && |(short_flags & ~mask_short_ch);
  assign warn_vis  = (flag_preot && !mask_preot) || (flag_preuv && !mask_preuv) ||
                     (flag_por && !mask_por);

  assign fault_pull = open_vis || short_vis || warn_vis || uvlo_in || otsd_in;
endmodule

module led_fault_monitor_chk #(
  parameter int NCH = 12
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] open_cmp,
  input logic [NCH-1:0] short_cmp,
  input logic           uvlo_in,
  input logic           otsd_in,
  input logic [NCH-1:0] mask_open_ch,
  input logic           mask_open_all,
  input logic [NCH-1:0] mask_short_ch,
  input logic           mask_short_all,
  input logic           mask_preot,
  input logic           mask_preuv,
  input logic           mask_por,
  input logic           clr_fault,
  input logic           clr_por,
  input logic [NCH-1:0] open_flags,
  input logic [NCH-1:0] short_flags,
  input logic           flag_preot,
  input logic           flag_preuv,
  input logic           flag_por,
  input logic           fault_pull
);
  for (genvar g = 0; g < NCH; g++) begin : g_a
    a_r1_open_needs_cmp: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(open_flags[g]) |-> $past(open_cmp[g]) && !$past(clr_fault));
    a_r3_short_needs_cmp: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(short_flags[g]) |-> $past(short_cmp[g]) && !$past(clr_fault));
    a_r6_open_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(open_flags[g]) |-> $past(clr_fault));
    a_r6_short_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(short_flags[g]) |-> $past(clr_fault));
  end

  a_r7_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    clr_fault |=> (open_flags == '0) && (short_flags == '0) && !flag_preot && !flag_preuv);

  a_r8_por_only_clr_por: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_por) |-> $past(clr_por));

  a_r8_por_never_rises: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(flag_por));

  a_r10_hard_fault_pulls: assert property (@(posedge clk) disable iff (!rst_n)
    (uvlo_in || otsd_in) |-> fault_pull);

  a_r9_all_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_open_all && mask_short_all && mask_preot && mask_preuv && mask_por &&
     !uvlo_in && !otsd_in) |-> !fault_pull);
endmodule

bind led_fault_monitor led_fault_monitor_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .open_cmp(open_cmp), .short_cmp(short_cmp),
  .uvlo_in(uvlo_in), .otsd_in(otsd_in), .mask_open_ch(mask_open_ch),
  .mask_open_all(mask_open_all), .mask_short_ch(mask_short_ch),
  .mask_short_all(mask_short_all), .mask_preot(mask_preot), .mask_preuv(mask_preuv),
  .mask_por(mask_por), .clr_fault(clr_fault), .clr_por(clr_por),
  .open_flags(open_flags), .short_flags(short_flags), .flag_preot(flag_preot),
  .flag_preuv(flag_preuv), .flag_por(flag_por), .fault_pull(fault_pull)
);

// File: tb/tb_led_fault_monitor.sv
module tb_led_fault_monitor;
  localparam int NCH  = 12;
  localparam int WARN = 40;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic           rst_n, pwm_tick, preuv_in, preot_in, uvlo_in, otsd_in;
  logic [1:0]     wait_sel;
  logic [NCH-1:0] open_cmp, short_cmp, mask_open_ch, mask_short_ch;
  logic           mask_open_all, mask_short_all, mask_preot, mask_preuv, mask_por;
  logic           clr_fault, clr_por;
  logic [NCH-1:0] open_flags, short_flags;
  logic           sum_open, sum_short, flag_preot, flag_preuv, flag_por, fault_pull;

  int checks = 0;
  int errors = 0;

  led_fault_monitor #(.NCH(NCH), .WARN_CYCLES(WARN)) dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int wait_len(input logic [1:0] ws);
    return 8 * (int'(ws) + 1);
  endfunction

  function automatic logic exp_pull(input logic [NCH-1:0] of, input logic [NCH-1:0] sf,
                                    input logic pot, input logic puv, input logic por);
    logic p;
    p = (!mask_open_all && |(of & ~mask_open_ch)) ||
        (!mask_short_all && |(sf & ~mask_short_ch)) ||
        (pot && !mask_preot) || (puv && !mask_preuv) || (por && !mask_por) ||
        uvlo_in || otsd_in;
    return p;
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    repeat (n) begin
      pwm_tick = 1'b1; @(negedge clk);
      pwm_tick = 1'b0; @(negedge clk);
    end
  endtask

  task automatic clear_faults();
    clr_fault = 1'b1; @(negedge clk); clr_fault = 1'b0;
  endtask

  task automatic no_masks();
    mask_open_ch = '0; mask_short_ch = '0; mask_open_all = 0; mask_short_all = 0;
    mask_preot = 0; mask_preuv = 0; mask_por = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'd1234));
    rst_n = 0; pwm_tick = 0; wait_sel = 0; open_cmp = '0; short_cmp = '0;
    preuv_in = 0; preot_in = 0; uvlo_in = 0; otsd_in = 0; clr_fault = 0; clr_por = 0;
    no_masks();
    cyc(3); rst_n = 1; cyc(2);

    chk("R8 por after reset", flag_por, 1);
    chk("R6 flags clear after reset", {open_flags, short_flags}, 0);
    chk("R9 por drives pin", fault_pull, 1);
    mask_por = 1; cyc(1);
    chk("R9 por masked", fault_pull, 0);
    clear_faults(); cyc(1);
    chk("R8 clr_fault keeps por", flag_por, 1);
    clr_por = 1; cyc(1); clr_por = 0; cyc(1);
    chk("R8 clr_por clears por", flag_por, 0);
    mask_por = 0;

    // R1 each wait code
    for (int ws = 0; ws < 4; ws++) begin
      wait_sel = 2'(ws); n = wait_len(2'(ws));
      clear_faults();
      open_cmp[ws*3] = 1'b1; cyc(1);
      ticks(n - 1); cyc(3);
      chk("R1 not yet at N-1", open_flags[ws*3], 0);
      ticks(1); cyc(1);
      chk("R1 set at N", open_flags[ws*3], 1);
      chk("R4 sum_open", sum_open, 1);
      open_cmp[ws*3] = 1'b0; cyc(4);
      chk("R6 open sticky", open_flags, NCH'(1) << (ws*3));
      chk("R9 open drives pin", fault_pull, 1);
    end

    // R2 restart
    wait_sel = 2'd1; n = 16;
    clear_faults(); chk("R7 cleared", {open_flags, short_flags}, 0);
    chk("R4 sum clear", {sum_open, sum_short}, 0);
    open_cmp[5] = 1; cyc(1); ticks(n - 1);
    open_cmp[5] = 0; cyc(1); open_cmp[5] = 1; cyc(1);
    ticks(n - 1); cyc(3);
    chk("R2 restart holds off", open_flags[5], 0);
    ticks(1); cyc(1);
    chk("R2 set after full run", open_flags[5], 1);
    open_cmp[5] = 0;

    // R3 short
    wait_sel = 2'd2; n = 24;
    clear_faults();
    short_cmp[11] = 1; cyc(1); ticks(n - 1); cyc(2);
    chk("R3 short not yet", short_flags[11], 0);
    ticks(1); cyc(1);
    chk("R3 short set", short_flags, 12'h800);
    chk("R4 sum_short", sum_short, 1);
    chk("R4 sum_open stays low", sum_open, 0);

    // R7 clear while present
    clear_faults();
    chk("R7 clear while present", short_flags[11], 0);
    ticks(n - 1); cyc(2);
    chk("R7 no early re-set", short_flags[11], 0);
    ticks(1); cyc(1);
    chk("R7 re-set after requalify", short_flags[11], 1);
    short_cmp[11] = 0; clear_faults();

    // R5 warnings
    preot_in = 1; cyc(WARN);
    chk("R5 preot not yet", flag_preot, 0);
    cyc(1);
    chk("R5 preot set", flag_preot, 1);
    preot_in = 0; cyc(3);
    chk("R6 preot sticky", flag_preot, 1);
    preuv_in = 1; cyc(WARN - 1); preuv_in = 0; cyc(1); preuv_in = 1; cyc(WARN);
    chk("R5 preuv interrupted", flag_preuv, 0);
    cyc(1);
    chk("R5 preuv set", flag_preuv, 1);
    preuv_in = 0;
    mask_preot = 1; cyc(1);
    chk("R9 preuv unmasked drives", fault_pull, 1);
    mask_preuv = 1; cyc(1);
    chk("R9 warnings masked", fault_pull, 0);
    clear_faults();
    chk("R7 warnings cleared", {flag_preot, flag_preuv}, 0);

    // R10
    mask_open_all = 1; mask_short_all = 1; mask_por = 1;
    uvlo_in = 1; cyc(1);
    chk("R10 uvlo forces", fault_pull, 1);
    uvlo_in = 0; otsd_in = 1; cyc(1);
    chk("R10 otsd forces", fault_pull, 1);
    otsd_in = 0; cyc(1);
    chk("R10 released", fault_pull, 0);

    // R11 masked channel still latches
    no_masks(); mask_por = 1; mask_open_ch[2] = 1; wait_sel = 0;
    open_cmp[2] = 1; cyc(1); ticks(8); cyc(1); open_cmp[2] = 0; cyc(1);
    chk("R11 masked flag latches", open_flags[2], 1);
    chk("R11 masked flag quiet", fault_pull, 0);
    mask_open_ch[2] = 0; cyc(1);
    chk("R9 unmask reveals", fault_pull, 1);

    // random
    for (int it = 0; it < 16; it++) begin
      logic [NCH-1:0] os, ss;
      no_masks();
      wait_sel = 2'($urandom % 4); n = wait_len(wait_sel);
      clear_faults();
      os = NCH'($urandom); ss = NCH'($urandom);
      open_cmp = os; short_cmp = ss; cyc(1);
      ticks(n); cyc(1);
      open_cmp = '0; short_cmp = '0; cyc(2);
      chk("R1 random open set", open_flags, os);
      chk("R3 random short set", short_flags, ss);
      chk("R4 random sums", {sum_open, sum_short}, {|os, |ss});
      for (int k = 0; k < 3; k++) begin
        mask_open_ch = NCH'($urandom); mask_short_ch = NCH'($urandom);
        mask_open_all = 1'($urandom); mask_short_all = 1'($urandom);
        mask_por = 1'($urandom); mask_preot = 1'($urandom); mask_preuv = 1'($urandom);
        cyc(1);
        chk("R9 random masks", fault_pull, exp_pull(os, ss, 1'b0, 1'b0, 1'b0));
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule